// File: doc/BRIEF.md
# Processor Status Word with Condition Flags

This block holds the 16-bit status word of a small processor core. After each ALU operation it records the condition flags: sign, zero, carry and a shared parity/overflow flag. It also holds control bits that only an explicit write changes: an interrupt enable, a register-bank select and a few mode bits. The ALU result can be byte-wide or word-wide. The flags always follow the active width. The parity/overflow flag changes meaning with the operation class. After arithmetic it records two's-complement overflow. After logic operations it records even parity of the result.

Software-visible access uses separate high-byte and low-byte write lanes. Any single bit can also be set, cleared or complemented. The carry flag doubles as a one-bit accumulator for bit-manipulation operations: load from a bit, store to a bit, AND with a bit and OR with a bit. A one-level shadow copy captures the whole word on interrupt entry and gives it back on return. All interfaces are plain single-cycle strobes with no back-pressure. The word updates on the clock edge at which a strobe is high, and every output is driven directly from the register.

Top module: `psw_reg`

## Requirements
- R1: Asynchronous active-low reset clears every bit of the status word and of the shadow copy to 0.
- R2: Layout: bit 0 CY, bit 1 LT, bit 2 PV, bit 3 IE, bit 4 AC, bit 5 RSS, bit 6 Z, bit 7 S, bits 14:12 bank select, bit 15 UF. Bits 11:8 always read 0, and any write or bit operation aimed at them is ignored.
- R3: `wr_hi_en` loads `wr_hi_data` into bits 15:8 and leaves bits 7:0 unchanged. `wr_lo_en` loads `wr_lo_data` into bits 7:0 and leaves bits 15:8 unchanged.
- R4: For arithmetic class (`alu_class`=2'b01), CY takes `alu_carry`. S takes bit 7 (when `alu_word`=0) or bit 15 (when `alu_word`=1) of `alu_res`. Z is 1 exactly when the result at the active width is zero.
- R5: For arithmetic class, PV takes `alu_ovf`.
- R6: For logic class (`alu_class`=2'b10), S and Z update as in R4. PV is 1 when the count of ones in the result at the active width is even, and 0 when it is odd. CY holds its value, and `alu_carry` and `alu_ovf` are ignored.
- R7: For `alu_class` 2'b00 or 2'b11 the word holds. An ALU update never changes LT, IE, AC, RSS or the high byte.
- R8: Priority per cycle is: restore, then byte writes, then bit operation, then ALU flag update. A lower action is dropped entirely when a higher one is present.
- R9: `bit_op` 3'd1 sets, 3'd2 clears and 3'd3 complements bit `bit_sel`. `bit_tst` always shows bit `bit_sel` of the current word.
- R10: Carry accumulator ops work on bit `bit_sel`: 3'd4 loads CY from the bit, 3'd5 stores CY into the bit, 3'd6 sets CY to CY AND bit, and 3'd7 sets CY to CY OR bit. 3'd0 does nothing.
- R11: `save_stb` copies the word held before that edge into the shadow copy. `restore_stb` reloads the whole word from the shadow copy on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_res | input | 16 | ALU result |
| alu_word | input | 1 | 1 = word operation, 0 = byte operation |
| alu_carry | input | 1 | Carry out or borrow in at the active MSB |
| alu_ovf | input | 1 | Two's-complement overflow of the operation |
| alu_class | input | 2 | 00 none, 01 arithmetic, 10 logic, 11 none |
| wr_hi_en | input | 1 | High-byte write strobe |
| wr_hi_data | input | 8 | High-byte write data |
| wr_lo_en | input | 1 | Low-byte write strobe |
| wr_lo_data | input | 8 | Low-byte write data |
| bit_op | input | 3 | Bit operation code (R9, R10) |
| bit_sel | input | 4 | Bit index for bit operations and test |
| save_stb | input | 1 | Capture the word into the shadow copy |
| restore_stb | input | 1 | Reload the word from the shadow copy |
| psw | output | 16 | Full status word |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_cy | output | 1 | Carry flag |
| flag_pv | output | 1 | Parity/overflow flag |
| bank_sel | output | 3 | Register-bank select |
| bit_tst | output | 1 | Selected bit of the word |

## Verification
The flag logic is exercised with results chosen to separate its cases:
- Zero in the low byte but not in the word shows whether Z follows the active width.
- A negative low byte with a positive word shows whether S comes from the correct MSB.
- Results with even and odd counts of ones, and an overflow input raised during logic operations, show whether PV switches meaning with the class.
- A preset carry during logic operations shows whether CY is left alone.

Same-cycle pairs of write, bit operation, restore and ALU update check the priority order. Save and write in one cycle checks that the shadow copy receives the old word.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'b00,
    CLS_ARITH = 2'b01,
    CLS_LOGIC = 2'b10,
    CLS_IDLE  = 2'b11
  } alu_class_e;

  typedef enum logic [2:0] {
    BOP_NOP  = 3'd0,
    BOP_SET  = 3'd1,
    BOP_CLR  = 3'd2,
    BOP_CPL  = 3'd3,
    BOP_LDC  = 3'd4,
    BOP_STC  = 3'd5,
    BOP_ANDC = 3'd6,
    BOP_ORC  = 3'd7
  } bit_op_e;

  localparam int POS_CY = 0;
  localparam int POS_LT = 1;
  localparam int POS_PV = 2;
  localparam int POS_IE = 3;
  localparam int POS_AC = 4;
  localparam int POS_RSS = 5;
  localparam int POS_Z = 6;
  localparam int POS_S = 7;
  localparam int POS_BANK = 12;
  localparam int BANK_W = 3;
  localparam int POS_UF = 15;
  localparam int RSV_LO = 8;
  localparam int RSV_W = 4;
endpackage

// File: rtl/psw_flag_eval.sv
module psw_flag_eval
  import psw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] res_i,
  input  logic         word_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  input  alu_class_e   cls_i,
  output logic         upd_o,
  output logic         cy_upd_o,
  output logic         s_o,
  output logic         z_o,
  output logic         pv_o,
  output logic         cy_o
);
  localparam int HW = W / 2;

  logic [W-1:0] active;

  always_comb begin
    active   = word_i ? res_i : {{(W-HW){1'b0}}, res_i[HW-1:0]};
    s_o      = word_i ? res_i[W-1] : res_i[HW-1];
    z_o      = (active == '0);
    pv_o     = (cls_i == CLS_ARITH) ? ovf_i : ~(^active);
    cy_o     = carry_i;
    upd_o    = (cls_i == CLS_ARITH) || (cls_i == CLS_LOGIC);
    cy_upd_o = (cls_i == CLS_ARITH);
  end
endmodule

// File: rtl/psw_bit_unit.sv
module psw_bit_unit
  import psw_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic [W-1:0]         cur_i,
  input  bit_op_e              op_i,
  input  logic [$clog2(W)-1:0] sel_i,
  output logic [W-1:0]         nxt_o,
  output logic                 active_o,
  output logic                 tst_o
);
  logic [W-1:0] tmp;
  logic         bv;

  always_comb begin
    tmp = cur_i;
    bv  = cur_i[sel_i];
    unique case (op_i)
      BOP_SET:  tmp[sel_i] = 1'b1;
      BOP_CLR:  tmp[sel_i] = 1'b0;
      BOP_CPL:  tmp[sel_i] = ~bv;
      BOP_LDC:  tmp[POS_CY] = bv;
      BOP_STC:  tmp[sel_i] = cur_i[POS_CY];
      BOP_ANDC: tmp[POS_CY] = cur_i[POS_CY] & bv;
      BOP_ORC:  tmp[POS_CY] = cur_i[POS_CY] | bv;
      default:  tmp = cur_i;
    endcase
    nxt_o    = tmp & WMASK;
    active_o = (op_i != BOP_NOP);
    tst_o    = bv;
  end
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         alu_res,
  input  logic                 alu_word,
  input  logic                 alu_carry,
  input  logic                 alu_ovf,
  input  logic [1:0]           alu_class,
  input  logic                 wr_hi_en,
  input  logic [W/2-1:0]       wr_hi_data,
  input  logic                 wr_lo_en,
  input  logic [W/2-1:0]       wr_lo_data,
  input  logic [2:0]           bit_op,
  input  logic [$clog2(W)-1:0] bit_sel,
  input  logic                 save_stb,
  input  logic                 restore_stb,
  output logic [W-1:0]         psw,
  output logic                 flag_s,
  output logic                 flag_z,
  output logic                 flag_cy,
  output logic                 flag_pv,
  output logic [BANK_W-1:0]    bank_sel,
  output logic                 bit_tst
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] WMASK = ~({{(W-RSV_W){1'b0}}, {RSV_W{1'b1}}} << RSV_LO);

  logic [W-1:0] psw_q, shadow_q, psw_d;
  logic [W-1:0] bit_nxt;
  logic         bit_act;
  logic         f_upd, f_cy_upd, f_s, f_z, f_pv, f_cy;

  psw_flag_eval #(.W(W)) u_flags (
    .res_i    (alu_res),
    .word_i   (alu_word),
    .carry_i  (alu_carry),
    .ovf_i    (alu_ovf),
    .cls_i    (alu_class_e'(alu_class)),
    .upd_o    (f_upd),
    .cy_upd_o (f_cy_upd),
    .s_o      (f_s),
    .z_o      (f_z),
    .pv_o     (f_pv),
    .cy_o     (f_cy)
  );

  psw_bit_unit #(.W(W), .WMASK(WMASK)) u_bits (
    .cur_i    (psw_q),
    .op_i     (bit_op_e'(bit_op)),
    .sel_i    (bit_sel),
    .nxt_o    (bit_nxt),
    .active_o (bit_act),
    .tst_o    (bit_tst)
  );

  always_comb begin
    psw_d = psw_q;
    if (restore_stb) begin
      psw_d = shadow_q;
    end else if (wr_hi_en || wr_lo_en) begin
      if (wr_hi_en) psw_d[W-1:HW] = wr_hi_data;
      if (wr_lo_en) psw_d[HW-1:0] = wr_lo_data;
      psw_d = psw_d & WMASK;
    end else if (bit_act) begin
      psw_d = bit_nxt;
    end else if (f_upd) begin
      psw_d[POS_S]  = f_s;
      psw_d[POS_Z]  = f_z;
      psw_d[POS_PV] = f_pv;
      if (f_cy_upd) psw_d[POS_CY] = f_cy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q    <= '0;
      shadow_q <= '0;
    end else begin
      psw_q <= psw_d;
      if (save_stb) shadow_q <= psw_q;
    end
  end

  assign psw      = psw_q;
  assign flag_s   = psw_q[POS_S];
  assign flag_z   = psw_q[POS_Z];
  assign flag_cy  = psw_q[POS_CY];
  assign flag_pv  = psw_q[POS_PV];
  assign bank_sel = psw_q[POS_BANK +: BANK_W];
endmodule

// File: rtl/psw_reg_chk.sv
module psw_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] alu_res,
  input logic        alu_word,
  input logic        alu_ovf,
  input logic [1:0]  alu_class,
  input logic        wr_hi_en,
  input logic [7:0]  wr_hi_data,
  input logic        wr_lo_en,
  input logic [7:0]  wr_lo_data,
  input logic [2:0]  bit_op,
  input logic        save_stb,
  input logic        restore_stb,
  input logic [15:0] psw,
  input logic        flag_z,
  input logic        flag_pv,
  input logic [15:0] shadow_q
);
  logic quiet;
  assign quiet = !restore_stb && !wr_hi_en && !wr_lo_en && (bit_op == 3'd0);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    psw[11:8] == 4'h0); // R2

  AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_en && !restore_stb) |=> psw[7:0] == $past(wr_lo_data)); // R3

  AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_en && !restore_stb) |=> psw[15:8] == {$past(wr_hi_data[7:4]), 4'h0}); // R3

  AST_ARITH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && alu_class == 2'b01) |=>
      flag_z == ($past(alu_word) ? ($past(alu_res) == 16'h0) : ($past(alu_res[7:0]) == 8'h0))); // R4

  AST_ARITH_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && alu_class == 2'b01) |=> flag_pv == $past(alu_ovf)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && alu_class[0] == alu_class[1]) |=> $stable(psw)); // R7

  AST_RESTORE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_stb |=> psw == $past(shadow_q)); // R11

  AST_SAVE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    save_stb |=> shadow_q == $past(psw)); // R11
endmodule

bind psw_reg psw_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alu_res     (alu_res),
  .alu_word    (alu_word),
  .alu_ovf     (alu_ovf),
  .alu_class   (alu_class),
  .wr_hi_en    (wr_hi_en),
  .wr_hi_data  (wr_hi_data),
  .wr_lo_en    (wr_lo_en),
  .wr_lo_data  (wr_lo_data),
  .bit_op      (bit_op),
  .save_stb    (save_stb),
  .restore_stb (restore_stb),
  .psw         (psw),
  .flag_z      (flag_z),
  .flag_pv     (flag_pv),
  .shadow_q    (shadow_q)
);

// File: tb/tb_psw_reg.sv
module tb_psw_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] alu_res = '0;
  logic        alu_word = 1'b0, alu_carry = 1'b0, alu_ovf = 1'b0;
  logic [1:0]  alu_class = 2'b00;
  logic        wr_hi_en = 1'b0, wr_lo_en = 1'b0;
  logic [7:0]  wr_hi_data = '0, wr_lo_data = '0;
  logic [2:0]  bit_op = 3'd0;
  logic [3:0]  bit_sel = '0;
  logic        save_stb = 1'b0, restore_stb = 1'b0;
  logic [15:0] psw;
  logic        flag_s, flag_z, flag_cy, flag_pv, bit_tst;
  logic [2:0]  bank_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psw_reg dut (
    .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_word(alu_word),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .alu_class(alu_class),
    .wr_hi_en(wr_hi_en), .wr_hi_data(wr_hi_data), .wr_lo_en(wr_lo_en),
    .wr_lo_data(wr_lo_data), .bit_op(bit_op), .bit_sel(bit_sel),
    .save_stb(save_stb), .restore_stb(restore_stb), .psw(psw),
    .flag_s(flag_s), .flag_z(flag_z), .flag_cy(flag_cy), .flag_pv(flag_pv),
    .bank_sel(bank_sel), .bit_tst(bit_tst)
  );

  // {pad3, preset_lo8, res16, word, carry, ovf, class2, expected_lo8}
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {3'b0, 8'h00, 16'h0000, 1'b0, 1'b1, 1'b0, 2'b01, 8'h41},
    {3'b0, 8'h00, 16'h1280, 1'b0, 1'b0, 1'b1, 2'b01, 8'h84},
    {3'b0, 8'h38, 16'h8000, 1'b1, 1'b0, 1'b0, 2'b01, 8'hB8},
    {3'b0, 8'hC5, 16'h0100, 1'b1, 1'b0, 1'b0, 2'b01, 8'h00},
    {3'b0, 8'h00, 16'h0100, 1'b0, 1'b1, 1'b1, 2'b01, 8'h45},
    {3'b0, 8'h01, 16'h0003, 1'b0, 1'b0, 1'b0, 2'b10, 8'h05},
    {3'b0, 8'h00, 16'h0007, 1'b0, 1'b0, 1'b1, 2'b10, 8'h00},
    {3'b0, 8'h00, 16'h8001, 1'b1, 1'b1, 1'b0, 2'b10, 8'h84},
    {3'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b10, 8'h44},
    {3'b0, 8'h02, 16'h0100, 1'b1, 1'b0, 1'b0, 2'b10, 8'h02},
    {3'b0, 8'hA5, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b00, 8'hA5},
    {3'b0, 8'h5A, 16'h0000, 1'b1, 1'b1, 1'b1, 2'b11, 8'h5A}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_class = 2'b00; wr_hi_en = 1'b0; wr_lo_en = 1'b0;
    bit_op = 3'd0; save_stb = 1'b0; restore_stb = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic write_lo(input logic [7:0] d);
    wr_lo_en = 1'b1; wr_lo_data = d; step();
  endtask

  task automatic do_bit(input logic [2:0] op, input logic [3:0] sel);
    bit_op = op; bit_sel = sel; step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", psw, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      write_lo(VEC[i][36:29]);
      alu_res = VEC[i][28:13]; alu_word = VEC[i][12]; alu_carry = VEC[i][11];
      alu_ovf = VEC[i][10]; alu_class = VEC[i][9:8];
      step();
      check($sformatf("R4 R5 R6 R7 vector %0d", i), psw, {8'h00, VEC[i][7:0]});
    end

    // R2 R3: high-byte write keeps low byte, reserved bits stay 0
    write_lo(8'h3C);
    wr_hi_en = 1'b1; wr_hi_data = 8'hFF; step();
    check("R2 R3 hi write", psw, 16'hF03C);
    check("R2 bank output", {13'b0, bank_sel}, 16'h0007);
    write_lo(8'h81);
    check("R3 lo write keeps hi", psw, 16'hF081);

    // R9 bit set/clear/complement/test
    do_bit(3'd1, 4'd3);
    check("R9 set IE", psw, 16'hF089);
    bit_sel = 4'd3; #1;
    check("R9 test bit", {15'b0, bit_tst}, 16'h0001);
    do_bit(3'd2, 4'd15);
    check("R9 clear UF", psw, 16'h7089);
    do_bit(3'd3, 4'd12);
    check("R9 complement bank bit", psw, 16'h6089);
    do_bit(3'd1, 4'd9);
    check("R2 reserved bit set ignored", psw, 16'h6089);

    // R10 carry accumulator
    do_bit(3'd2, 4'd0);
    check("R10 clear CY", psw, 16'h6088);
    do_bit(3'd6, 4'd7);
    check("R10 and into CY", psw, 16'h6088);
    do_bit(3'd7, 4'd7);
    check("R10 or into CY", psw, 16'h6089);
    do_bit(3'd5, 4'd5);
    check("R10 store CY", psw, 16'h60A9);
    do_bit(3'd4, 4'd2);
    check("R10 load CY", psw, 16'h60A8);
    check("R10 flag_cy", {15'b0, flag_cy}, 16'h0000);

    // R8 priority
    wr_lo_en = 1'b1; wr_lo_data = 8'h11;
    alu_class = 2'b01; alu_res = 16'h0000; alu_carry = 1'b1; alu_word = 1'b0;
    step();
    check("R8 write over flags", psw, 16'h6011);
    bit_op = 3'd1; bit_sel = 4'd6;
    alu_class = 2'b01; alu_res = 16'h00FF; alu_carry = 1'b0; alu_ovf = 1'b0;
    step();
    check("R8 bit op over flags", psw, 16'h6051);
    save_stb = 1'b1; step();
    write_lo(8'h00);
    check("R11 after save", psw, 16'h6000);
    restore_stb = 1'b1; wr_lo_en = 1'b1; wr_lo_data = 8'hFF;
    wr_hi_en = 1'b1; wr_hi_data = 8'h00; step();
    check("R8 R11 restore over write", psw, 16'h6051);

    // R11 save takes the old word when a write lands in the same cycle
    save_stb = 1'b1; wr_lo_en = 1'b1; wr_lo_data = 8'h22; step();
    check("R11 write with save", psw, 16'h6022);
    restore_stb = 1'b1; step();
    check("R11 restore old word", psw, 16'h6051);

    // R6 logic keeps carry
    write_lo(8'h01);
    alu_class = 2'b10; alu_res = 16'h0001; alu_word = 1'b0; alu_carry = 1'b0; alu_ovf = 1'b1;
    step();
    check("R6 logic odd parity keeps CY", psw, 16'h6001);
    check("R6 flag_pv", {15'b0, flag_pv}, 16'h0000);

    // R1 reset clears shadow too
    rst_n = 1'b0; #1;
    check("R1 async reset", psw, 16'h0000);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    restore_stb = 1'b1; step();
    check("R1 shadow cleared", psw, 16'h0000);

    done = 1'b1;
    finish_run();
  end
endmodule